// File: doc/BRIEF.md
# Page-Mode Multiplexed-Address Memory Controller

This block reads 64-bit words from a memory module built out of eight small dynamic memory chips. Every chip holds a grid of 4 rows by 4 columns of byte-wide cells. Each chip has one narrow address port that is used twice per access. During a row strobe it carries the row index, and the chip copies that whole row into an internal row buffer. During a column strobe it carries the column index, and the chip picks one byte out of that buffer. All eight chips see the same address and strobes, and each chip supplies its own byte lane of the word.

The controller takes one read request at a time over a valid/ready handshake. It remembers which row is open in the chips' row buffers. A request that hits the open row skips the row strobe and goes straight to the column strobe, which is page-mode operation. Any other request opens its row first. The chips hold fixed contents, so the data on every access can be predicted.

Top module: `page_dram_top`

## Requirements
- R1: While reset is applied and after it is released, `req_ready` is 1 and `rsp_valid`, `row_strobe` and `col_strobe` are all 0.
- R2: A request whose row differs from the open row gives a row strobe in the first cycle after acceptance, with `chip_addr` equal to the row. A column strobe follows in the next cycle with `chip_addr` equal to the column. `rsp_valid` rises in the third cycle after acceptance.
- R3: A request to the row that is currently open gives no row strobe. The column strobe comes in the first cycle after acceptance, with `chip_addr` equal to the column, and `rsp_valid` rises in the second cycle.
- R4: The response word holds byte k (bits 8k+7 down to 8k) equal to (16*k + 4*row + col) mod 256 for k = 0..7.
- R5: `rsp_valid` lasts exactly one cycle per accepted request.
- R6: `req_ready` is 0 from the cycle after acceptance until the response cycle has ended, so only one request is in flight.
- R7: Reset forgets the open row, so the first request after reset always performs a row strobe, even to the row that was open before reset.
- R8: `row_strobe` and `col_strobe` are never high in the same cycle, and every row strobe is followed directly by a column strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_row | input | 2 | Row index of the request |
| req_col | input | 2 | Column index of the request |
| row_strobe | output | 1 | Row strobe sent to all chips |
| col_strobe | output | 1 | Column strobe sent to all chips |
| chip_addr | output | 2 | Shared multiplexed chip address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 64 | Assembled 64-bit word |

## Verification
A request to a new row produces its row strobe one cycle after acceptance and its column strobe two cycles after, and the response appears three cycles after acceptance. A request to the open row produces its column strobe one cycle after acceptance and its response two cycles after. The driver counts cycles from the acceptance edge and samples every strobe, the address and `req_ready` on falling edges, so each value is read in the cycle it is due. A separate monitor takes every response pulse off the scoreboard queue, compares the data, and checks that the pulse has dropped by the next falling edge.

// File: rtl/page_dram_pkg.sv
package page_dram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2,
    ST_DATA = 2'd3
  } ctrl_state_t;
endpackage

// File: rtl/page_dram_chip.sv
module page_dram_chip #(
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int CELL_W   = 8,
  parameter int AW       = 2,
  parameter int CHIP_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras,
  input  logic              cas,
  input  logic [AW-1:0]     addr,
  output logic [CELL_W-1:0] dq
);
  localparam int CELLS = ROWS * COLS;

  logic [CELL_W-1:0] buf_q [COLS];
  logic [CELL_W-1:0] buf_d [COLS];
  logic [CELL_W-1:0] dq_d;

  function automatic logic [CELL_W-1:0] cell_val(input int r, input int c);
    cell_val = CELL_W'(CHIP_IDX * CELLS + r * COLS + c);
  endfunction

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      buf_d[c] = buf_q[c];
      if (ras) buf_d[c] = cell_val(int'(addr), c);
    end
    dq_d = dq;
    if (cas) dq_d = buf_q[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) buf_q[c] <= '0;
      dq <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) buf_q[c] <= buf_d[c];
      dq <= dq_d;
    end
  end
endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl
  import page_dram_pkg::*;
#(
  parameter int RW = 2,
  parameter int CW = 2,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  output logic          row_strobe,
  output logic          col_strobe,
  output logic [AW-1:0] chip_addr,
  output logic          rsp_valid
);
  ctrl_state_t   state_q, state_d;
  logic [RW-1:0] row_q, row_d, open_row_q, open_row_d;
  logic [CW-1:0] col_q, col_d;
  logic          open_vld_q, open_vld_d;

  always_comb begin
    state_d    = state_q;
    row_d      = row_q;
    col_d      = col_q;
    open_row_d = open_row_q;
    open_vld_d = open_vld_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        row_d = req_row;
        col_d = req_col;
        state_d = (open_vld_q && (req_row == open_row_q)) ? ST_COL : ST_ROW;
      end
      ST_ROW: begin
        open_row_d = row_q;
        open_vld_d = 1'b1;
        state_d    = ST_COL;
      end
      ST_COL:  state_d = ST_DATA;
      ST_DATA: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      open_row_q <= '0;
      open_vld_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      row_q      <= row_d;
      col_q      <= col_d;
      open_row_q <= open_row_d;
      open_vld_q <= open_vld_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign row_strobe = (state_q == ST_ROW);
  assign col_strobe = (state_q == ST_COL);
  assign rsp_valid  = (state_q == ST_DATA);

  always_comb begin
    chip_addr = '0;
    if (row_strobe) chip_addr = AW'(row_q);
    if (col_strobe) chip_addr = AW'(col_q);
  end
endmodule

// File: rtl/page_dram_top.sv
module page_dram_top #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int CELL_W = 8,
  parameter int NCHIP  = 8,
  parameter int RW     = $clog2(ROWS),
  parameter int CW     = $clog2(COLS),
  parameter int AW     = (RW > CW) ? RW : CW,
  parameter int DW     = NCHIP * CELL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  output logic          row_strobe,
  output logic          col_strobe,
  output logic [AW-1:0] chip_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [DW-1:0] lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  page_dram_ctrl #(.RW(RW), .CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col),
    .row_strobe(row_strobe), .col_strobe(col_strobe),
    .chip_addr(chip_addr), .rsp_valid(rsp_valid)
  );

  for (genvar k = 0; k < NCHIP; k++) begin : g_chip
    page_dram_chip #(
      .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .AW(AW), .CHIP_IDX(k)
    ) u_chip (
      .clk(clk), .rst_n(rst_int_n),
      .ras(row_strobe), .cas(col_strobe), .addr(chip_addr),
      .dq(lanes[k*CELL_W +: CELL_W])
    );
  end

  assign rsp_data = rsp_valid ? lanes : '0;
endmodule

// File: rtl/page_dram_chk.sv
module page_dram_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic row_strobe,
  input logic col_strobe,
  input logic rsp_valid
);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_strobe, col_strobe}));

  p_row_then_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    row_strobe |=> col_strobe);

  p_col_then_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe |=> rsp_valid);

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_ready_on_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!rsp_valid);
    end
  end
endmodule

bind page_dram_top page_dram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .row_strobe(row_strobe), .col_strobe(col_strobe), .rsp_valid(rsp_valid)
);

// File: tb/page_dram_top_bench.sv
module page_dram_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_row, req_col;
  logic        row_strobe, col_strobe;
  logic [1:0]  chip_addr;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q[$];

  always #10 clk = ~clk;

  page_dram_top u_page_dram_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .row_strobe(row_strobe),
    .col_strobe(col_strobe), .chip_addr(chip_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  function automatic logic [63:0] word_of(input int r, input int c);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = 8'((16*k + 4*r + c) % 256);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: response data and pulse width (R4, R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        logic [63:0] e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected response", longint'(rsp_data[31:0]), 0);
        end else begin
          e = exp_q.pop_front();
          check(rsp_data == e, "R4 data low", longint'(rsp_data[31:0]), longint'(e[31:0]));
          check(rsp_data == e, "R4 data high", longint'(rsp_data[63:32]), longint'(e[63:32]));
        end
        @(negedge clk);
        check(!rsp_valid, "R5 pulse width", longint'(rsp_valid), 0);
      end
    end
  end

  // Driver: one request; hit says whether the row is expected open (R2, R3, R6, R7)
  task automatic do_req(input int r, input int c, input bit hit, input string tag);
    int n = 0;
    int ras_cnt = 0;
    int ras_at = -1;
    int cas_at = -1;
    int ras_adr = -1;
    int cas_adr = -1;
    bit busy_ok = 1'b1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_row = 2'(r);
    req_col = 2'(c);
    exp_q.push_back(word_of(r, c));
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 10) begin
      if (row_strobe) begin ras_cnt++; ras_at = n; ras_adr = int'(chip_addr); end
      if (col_strobe) begin cas_at = n; cas_adr = int'(chip_addr); end
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    if (req_ready) busy_ok = 1'b0;
    check(busy_ok, "R6 ready low while busy", 0, 0);
    if (hit) begin
      check(ras_cnt == 0, {tag, " R3 no row strobe"}, ras_cnt, 0);
      check(cas_at == 1, {tag, " R3 col strobe cycle"}, cas_at, 1);
      check(n == 2, {tag, " R3 latency"}, n, 2);
    end else begin
      check(ras_cnt == 1 && ras_at == 1, {tag, " R2 row strobe cycle"}, ras_at, 1);
      check(ras_adr == r, {tag, " R2 row address"}, ras_adr, r);
      check(cas_at == 2, {tag, " R2 col strobe cycle"}, cas_at, 2);
      check(n == 3, {tag, " R2 latency"}, n, 3);
    end
    check(cas_adr == c, {tag, " R2 col address"}, cas_adr, c);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_row = '0;
    req_col = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !row_strobe && !col_strobe, "R1 in reset",
          longint'({req_ready, rsp_valid, row_strobe, col_strobe}), 8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !row_strobe && !col_strobe, "R1 after reset",
          longint'({req_ready, rsp_valid, row_strobe, col_strobe}), 8);

    do_req(1, 2, 1'b0, "R7 first after reset");
    do_req(1, 3, 1'b1, "page hit");
    do_req(1, 0, 1'b1, "page hit col0");
    do_req(3, 3, 1'b0, "row change");
    do_req(3, 1, 1'b1, "page hit row3");
    do_req(0, 0, 1'b0, "row zero");
    do_req(0, 3, 1'b1, "page hit row0");
    do_req(2, 1, 1'b0, "row two");
    do_req(2, 1, 1'b1, "repeat same cell");

    // R7: reset forgets the open row
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R1 mid reset", longint'({rsp_valid, req_ready}), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_req(2, 2, 1'b0, "R7 same row after reset");
    do_req(2, 0, 1'b1, "R7 hit after reopen");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule